// File: doc/BRIEF.md
# System Clock-Enable Divider with Automatic Switchback

This block produces a one-cycle clock-enable strobe, `sys_ce`, that paces the machine cycle of a processor core. It runs from a reference clock at four times the crystal frequency. A small power-management register holds four fields: a two-bit divide code, a multiplier-enable bit, a quad/double select bit and a switchback-enable bit. Together these choose a machine cycle of 0.25, 0.5, 1 or 1024 crystal periods, which is 1, 2, 4 or 4096 reference cycles. Software can write the register in any cycle.

Switchback lets a core that is idling in the slowest mode wake up quickly. It applies only when the divide code selects divide-by-1024 and switchback is enabled. In that state, an enabled external interrupt event or a detected serial start bit returns the divide code to divide-by-1 without software action. Software can read the divide code back to see that a switchback has taken place. Any change of setting, whether from a write or from switchback, restarts the divide counter, so the next strobe follows the new period.

Top module: `clkdiv_switchback`

## Requirements
- R1: After reset the divide code reads 2'b10, and the first strobe comes in the 4th cycle after reset is released, then one every 4 cycles.
- R2: Divide code 2'b10 gives one strobe every 4 reference cycles.
- R3: The reserved divide code 2'b01 reads back as written and behaves exactly like 2'b10 (period 4).
- R4: Divide code 2'b11 gives one strobe every 4096 reference cycles.
- R5: Divide code 2'b00 with multiplier enable 1 gives a period of 1 when quad select is 1 and a period of 2 when quad select is 0.
- R6: Divide code 2'b00 with multiplier enable 0 is treated as divide-by-1 (period 4).
- R7: A synchronous reset asserted in any mode restores divide code 2'b10 and the period of 4.
- R8: In code 2'b11 with switchback enable 1, an `ext_irq` pulse changes the divide code to 2'b10 at the next edge.
- R9: In code 2'b11 with switchback enable 1, a `ser_start` pulse changes the divide code to 2'b10 at the next edge.
- R10: With switchback enable 0, or in any code other than 2'b11, `ext_irq` and `ser_start` leave the divide code and the strobe period unchanged.
- R11: A register write or a switchback restarts the counter, so the first strobe after the update edge comes exactly one new period after that edge.
- R12: When a write and a switchback fall in the same cycle, the divide code becomes 2'b10. The write's other fields still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, four times the crystal rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_div_code | input | 2 | Divide code to write (00 multiplier, 01 reserved, 10 divide-by-1, 11 divide-by-1024) |
| wr_mul_on | input | 1 | Multiplier enable to write |
| wr_quad_sel | input | 1 | Quad select to write (1 = 0.25, 0 = 0.5 crystal periods) |
| wr_sback_en | input | 1 | Switchback enable to write |
| ext_irq | input | 1 | Enabled external interrupt detected (one-cycle event) |
| ser_start | input | 1 | Serial start bit detected (one-cycle event) |
| sys_ce | output | 1 | Machine-cycle clock-enable strobe |
| rd_div_code | output | 2 | Current divide code |

## Verification
The hardest case to reach is a write and a wake-up event landing in the same cycle while the block is already in the slow mode with switchback armed. The bench first writes code 11 with switchback enabled. It then drives `wr_en` with a fast multiplier setting together with `ext_irq` on a single falling edge. It checks that the divide code reads 10 and that the period is 4 rather than 1. The 4096-cycle period is also measured in full from the edge of the write.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        CD_MULT  = 2'b00,
        CD_RSVD  = 2'b01,
        CD_UNITY = 2'b10,
        CD_SLOW  = 2'b11
    } div_code_e;

    typedef enum logic [1:0] {
        RATE_QUARTER,
        RATE_HALF,
        RATE_UNITY,
        RATE_SLOW
    } rate_e;

    typedef struct packed {
        div_code_e code;
        logic      mul_on;
        logic      quad_sel;
        logic      sback_en;
    } pm_reg_t;

    localparam pm_reg_t PM_RESET = '{
        code:     CD_UNITY,
        mul_on:   1'b0,
        quad_sel: 1'b0,
        sback_en: 1'b0
    };

    // Map the register contents to an effective machine-cycle rate.
    function automatic rate_e decode_rate(input pm_reg_t r);
        rate_e res;
        case (r.code)
            CD_SLOW:  res = RATE_SLOW;
            CD_MULT:  res = r.mul_on ? (r.quad_sel ? RATE_QUARTER : RATE_HALF)
                                     : RATE_UNITY;
            default:  res = RATE_UNITY;   // 10b and reserved 01b
        endcase
        return res;
    endfunction

    // True when a wake-up event must force the slow mode back to unity.
    function automatic logic wake_hit(input pm_reg_t r, input logic irq,
                                      input logic start);
        return r.sback_en && (r.code == CD_SLOW) && (irq || start);
    endfunction

endpackage

// File: rtl/clkdiv_pm_reg.sv
module clkdiv_pm_reg
    import clkdiv_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  pm_reg_t wr_val,
    input  logic    ext_irq,
    input  logic    ser_start,
    output pm_reg_t pm_q,
    output logic    restart
);

    pm_reg_t pm_d;
    logic    sb_hit;

    assign sb_hit  = wake_hit(pm_q, ext_irq, ser_start);
    assign restart = wr_en || sb_hit;

    always_comb begin
        pm_d = pm_q;
        if (wr_en) begin
            pm_d = wr_val;
        end
        if (sb_hit) begin
            pm_d.code = CD_UNITY;   // switchback wins over a concurrent write
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pm_q <= PM_RESET;
        end else begin
            pm_q <= pm_d;
        end
    end

endmodule

// File: rtl/clkdiv_rate_sel.sv
module clkdiv_rate_sel
    import clkdiv_pkg::*;
#(
    parameter int unsigned REF_MULT = 4,
    parameter int unsigned SLOW_DIV = 1024,
    parameter int unsigned CNT_W    = 12
) (
    input  pm_reg_t           cfg,
    output rate_e             rate,
    output logic [CNT_W-1:0]  period_m1
);

    localparam int unsigned P_QUARTER = REF_MULT / 4;
    localparam int unsigned P_HALF    = REF_MULT / 2;
    localparam int unsigned P_UNITY   = REF_MULT;
    localparam int unsigned P_SLOW    = REF_MULT * SLOW_DIV;

    localparam logic [CNT_W-1:0] M_QUARTER = CNT_W'(P_QUARTER - 1);
    localparam logic [CNT_W-1:0] M_HALF    = CNT_W'(P_HALF - 1);
    localparam logic [CNT_W-1:0] M_UNITY   = CNT_W'(P_UNITY - 1);
    localparam logic [CNT_W-1:0] M_SLOW    = CNT_W'(P_SLOW - 1);

    assign rate = decode_rate(cfg);

    always_comb begin
        case (rate)
            RATE_QUARTER: period_m1 = M_QUARTER;
            RATE_HALF:    period_m1 = M_HALF;
            RATE_SLOW:    period_m1 = M_SLOW;
            default:      period_m1 = M_UNITY;
        endcase
    end

endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [CNT_W-1:0] period_m1,
    output logic             strobe
);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap   = (cnt_q >= period_m1);
    assign strobe = (cnt_q == period_m1);

    always_ff @(posedge clk) begin
        if (rst || restart || wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/clkdiv_switchback.sv
module clkdiv_switchback
    import clkdiv_pkg::*;
#(
    parameter int unsigned REF_MULT = 4,
    parameter int unsigned SLOW_DIV = 1024
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_div_code,
    input  logic       wr_mul_on,
    input  logic       wr_quad_sel,
    input  logic       wr_sback_en,
    input  logic       ext_irq,
    input  logic       ser_start,
    output logic       sys_ce,
    output logic [1:0] rd_div_code
);

    localparam int unsigned CNT_W = $clog2(REF_MULT * SLOW_DIV);

    pm_reg_t          wr_val;
    pm_reg_t          pm_q;
    rate_e            rate;
    logic             restart;
    logic [CNT_W-1:0] period_m1;
    logic             sback_q;
    logic             one_cycle;

    assign wr_val = '{
        code:     div_code_e'(wr_div_code),
        mul_on:   wr_mul_on,
        quad_sel: wr_quad_sel,
        sback_en: wr_sback_en
    };

    clkdiv_pm_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_val    (wr_val),
        .ext_irq   (ext_irq),
        .ser_start (ser_start),
        .pm_q      (pm_q),
        .restart   (restart)
    );

    clkdiv_rate_sel #(
        .REF_MULT (REF_MULT),
        .SLOW_DIV (SLOW_DIV),
        .CNT_W    (CNT_W)
    ) u_rate (
        .cfg       (pm_q),
        .rate      (rate),
        .period_m1 (period_m1)
    );

    clkdiv_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .period_m1 (period_m1),
        .strobe    (sys_ce)
    );

    assign rd_div_code = pm_q.code;
    assign sback_q     = pm_q.sback_en;
    assign one_cycle   = (rate == RATE_QUARTER) && (period_m1 == '0);

endmodule

// File: rtl/clkdiv_switchback_chk.sv
module clkdiv_switchback_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       ext_irq,
    input logic       ser_start,
    input logic       sys_ce,
    input logic [1:0] rd_div_code,
    input logic       sback_q,
    input logic       one_cycle
);

    AST_RESET_UNITY: assert property (@(posedge clk)
        $past(rst) |-> rd_div_code == 2'b10);  // R7

    AST_WAKE_IRQ: assert property (@(posedge clk) disable iff (rst)
        (rd_div_code == 2'b11 && sback_q && ext_irq) |=> rd_div_code == 2'b10);  // R8

    AST_WAKE_SER: assert property (@(posedge clk) disable iff (rst)
        (rd_div_code == 2'b11 && sback_q && ser_start) |=> rd_div_code == 2'b10);  // R9

    AST_NO_WAKE_ELSE: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !(rd_div_code == 2'b11 && sback_q)) |=> $stable(rd_div_code));  // R10

    AST_WRITE_WAKE_PRIO: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_div_code == 2'b11 && sback_q && (ext_irq || ser_start))
        |=> rd_div_code == 2'b10);  // R12

    AST_FAST_EVERY: assert property (@(posedge clk) disable iff (rst)
        one_cycle |-> sys_ce);  // R5

    AST_SLOW_GAP: assert property (@(posedge clk) disable iff (rst)
        (sys_ce && rd_div_code == 2'b11 && !wr_en && !(sback_q && (ext_irq || ser_start)))
        |=> !sys_ce);  // R4

endmodule

bind clkdiv_switchback clkdiv_switchback_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .ext_irq     (ext_irq),
    .ser_start   (ser_start),
    .sys_ce      (sys_ce),
    .rd_div_code (rd_div_code),
    .sback_q     (sback_q),
    .one_cycle   (one_cycle)
);

// File: tb/sim_clkdiv_switchback.sv
module sim_clkdiv_switchback;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_div_code = 2'b10;
    logic       wr_mul_on = 1'b0;
    logic       wr_quad_sel = 1'b0;
    logic       wr_sback_en = 1'b0;
    logic       ext_irq = 1'b0;
    logic       ser_start = 1'b0;
    logic       sys_ce;
    logic [1:0] rd_div_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    clkdiv_switchback u0 (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_div_code (wr_div_code),
        .wr_mul_on   (wr_mul_on),
        .wr_quad_sel (wr_quad_sel),
        .wr_sback_en (wr_sback_en),
        .ext_irq     (ext_irq),
        .ser_start   (ser_start),
        .sys_ce      (sys_ce),
        .rd_div_code (rd_div_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count cycles from the current negedge until a strobe is seen.
    task automatic until_strobe(output int n);
        n = 1;
        while (!sys_ce && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Measure first strobe after an update edge, then the following gap.
    task automatic measure(input string req, input int exp);
        int n;
        until_strobe(n);
        check(n == exp, req, n, exp);
        @(negedge clk);
        until_strobe(n);
        check(n == exp, req, n, exp);
    endtask

    task automatic write_reg(input logic [1:0] code, input logic mul, input logic quad,
                             input logic sb);
        wr_en = 1'b1; wr_div_code = code; wr_mul_on = mul;
        wr_quad_sel = quad; wr_sback_en = sb;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(rd_div_code == 2'b10, "R1", rd_div_code, 2);
        measure("R1", 4);
    endtask

    task automatic t_modes;
        write_reg(2'b10, 1'b0, 1'b0, 1'b0);
        measure("R2", 4);
        write_reg(2'b01, 1'b0, 1'b0, 1'b0);
        check(rd_div_code == 2'b01, "R3", rd_div_code, 1);
        measure("R3", 4);
        write_reg(2'b00, 1'b1, 1'b1, 1'b0);
        measure("R5", 1);
        write_reg(2'b00, 1'b1, 1'b0, 1'b0);
        measure("R5", 2);
        write_reg(2'b00, 1'b0, 1'b1, 1'b0);
        measure("R6", 4);
        write_reg(2'b11, 1'b0, 1'b0, 1'b0);
        measure("R4", 4096);
    endtask

    task automatic t_restart;
        write_reg(2'b10, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        write_reg(2'b10, 1'b0, 1'b0, 1'b0);   // mid-count rewrite
        measure("R11", 4);
    endtask

    task automatic t_reset_mid;
        write_reg(2'b00, 1'b1, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(rd_div_code == 2'b10, "R7", rd_div_code, 2);
        measure("R7", 4);
    endtask

    task automatic t_wake_irq;
        write_reg(2'b11, 1'b0, 1'b0, 1'b1);
        repeat (20) @(negedge clk);
        ext_irq = 1'b1;
        @(negedge clk);
        ext_irq = 1'b0;
        check(rd_div_code == 2'b10, "R8", rd_div_code, 2);
        measure("R11", 4);
    endtask

    task automatic t_wake_ser;
        write_reg(2'b11, 1'b0, 1'b0, 1'b1);
        repeat (7) @(negedge clk);
        ser_start = 1'b1;
        @(negedge clk);
        ser_start = 1'b0;
        check(rd_div_code == 2'b10, "R9", rd_div_code, 2);
        measure("R9", 4);
    endtask

    task automatic t_no_wake;
        int n;
        // slow mode, switchback disabled
        write_reg(2'b11, 1'b0, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        ext_irq = 1'b1; ser_start = 1'b1;
        @(negedge clk);
        ext_irq = 1'b0; ser_start = 1'b0;
        check(rd_div_code == 2'b11, "R10", rd_div_code, 3);
        until_strobe(n);
        check(n == 4096 - 6, "R10", n, 4096 - 6);
        // unity mode with switchback enabled
        write_reg(2'b10, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        ser_start = 1'b1; ext_irq = 1'b1;
        @(negedge clk);
        ser_start = 1'b0; ext_irq = 1'b0;
        check(rd_div_code == 2'b10, "R10", rd_div_code, 2);
        until_strobe(n);
        check(n == 2, "R10", n, 2);
        // multiplier mode with switchback enabled
        write_reg(2'b00, 1'b1, 1'b0, 1'b1);
        ext_irq = 1'b1;
        @(negedge clk);
        ext_irq = 1'b0;
        check(rd_div_code == 2'b00, "R10", rd_div_code, 0);
    endtask

    task automatic t_priority;
        write_reg(2'b11, 1'b0, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        ext_irq = 1'b1;
        write_reg(2'b00, 1'b1, 1'b1, 1'b1);
        ext_irq = 1'b0;
        check(rd_div_code == 2'b10, "R12", rd_div_code, 2);
        measure("R12", 4);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_modes();
        t_restart();
        t_reset_mid();
        t_wake_irq();
        t_wake_ser();
        t_no_wake();
        t_priority();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule